// File: doc/BRIEF.md
# Timer Run and External Interrupt Flag Register

This block is one byte-wide control and status register for a small microcontroller core. It holds a run enable for each of two timers and latches an overflow flag for each. It also holds two external interrupt request flags. Each of these has a select bit that makes it either follow its active-low pin (level mode) or catch a high-to-low transition on that pin (edge mode). The core reads the register as a whole. It can write it as a byte or one bit at a time through the bit-addressable window. The interrupt controller takes the four flags as requests and returns a one-cycle acknowledge strobe when it vectors to a handler.

Each external pin passes through a two-flop synchroniser. A two-state machine per pin then follows the synchronised pin. Its states are PIN_HIGH and PIN_LOW. The transition FALL goes from PIN_HIGH to PIN_LOW when the pin reads active (low), and this transition is the edge event that edge mode latches. The transition RISE goes from PIN_LOW back to PIN_HIGH when the pin reads inactive. Each state holds while the pin keeps its level. The flag logic has a fixed order of precedence. A hardware set comes first, then an acknowledge clear, then a bus write. Level mode overrides all three.

Top module: `tmr_xint_ctl`

## Requirements
- R1: Bit positions from bit 7 down to bit 0 are timer-1 overflow, timer-1 run, timer-0 overflow, timer-0 run, ext-1 flag, ext-1 mode, ext-0 flag, ext-0 mode (mode 1 = edge, 0 = level). A byte write to address SFR_ADDR (default 0x88) loads all eight bits. `sfr_rdata` always shows the live register.
- R2: While `rst_n` is low the register reads 0x0A: both external flags are set and all other bits are clear.
- R3: A one-cycle `tmr_ovf[i]` pulse sets the overflow flag of timer i at the next clock edge.
- R4: A `tmr_ack[i]` strobe, or a write of 0 to the flag, clears the overflow flag of timer i at the next clock edge.
- R5: When a hardware set (an overflow pulse or a latched pin edge) lands in the same cycle as an acknowledge or a clearing write, the flag ends up set.
- R6: `tmr_run[i]` equals the timer-i run bit and changes only through bus writes.
- R7: In edge mode a high-to-low transition on `xint_n[i]` sets flag i on the third clock edge after the pin changes. A pin that stays low does not set the flag again after it is cleared, and a low-to-high transition never sets it.
- R8: In edge mode `xint_ack[i]` or a write of 0 clears flag i.
- R9: In level mode flag i equals the inverse of `xint_n[i]` delayed by three clock edges. Acknowledge strobes and writes to the flag leave no lasting effect.
- R10: A bit write to address SFR_ADDR+n (n = 0..7) changes only bit n.
- R11: Byte writes to any address other than SFR_ADDR, and bit writes outside SFR_ADDR..SFR_ADDR+7, change no bit.
- R12: `tmr_irq[i]` and `xint_irq[i]` equal the corresponding overflow and external flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | Byte address or bit address of the access |
| sfr_wr_byte | input | 1 | Byte write strobe |
| sfr_wr_bit | input | 1 | Single-bit write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_bit_val | input | 1 | Single-bit write value |
| tmr_ovf | input | 2 | Overflow pulses from timers 1..0 |
| xint_n | input | 2 | External interrupt pins 1..0, active low |
| tmr_ack | input | 2 | Vector acknowledge for timer interrupts 1..0 |
| xint_ack | input | 2 | Vector acknowledge for external interrupts 1..0 |
| sfr_rdata | output | 8 | Live register value |
| tmr_run | output | 2 | Timer run enables 1..0 |
| tmr_irq | output | 2 | Timer overflow requests 1..0 |
| xint_irq | output | 2 | External interrupt requests 1..0 |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives in the very cycle a pin edge is latched. That edge event exists only inside the block, two clock edges after the pin falls. The bench drops the pin on a falling clock edge. It counts two more falling edges, then raises the acknowledge for exactly the cycle in which the edge is registered, and expects the flag to stay set. The same counting places the level-mode latency checks on the cycle before and the cycle of the flag change.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;

    localparam int unsigned REG_W = 8;

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] val;
    } reg_wr_t;

    typedef enum logic {
        PIN_HIGH = 1'b0,
        PIN_LOW  = 1'b1
    } pin_state_e;

    function automatic int unsigned pos_tf(input int unsigned ch);
        return 5 + 2 * ch;
    endfunction

    function automatic int unsigned pos_tr(input int unsigned ch);
        return 4 + 2 * ch;
    endfunction

    function automatic int unsigned pos_ie(input int unsigned ch);
        return 1 + 2 * ch;
    endfunction

    function automatic int unsigned pos_it(input int unsigned ch);
        return 2 * ch;
    endfunction

endpackage

// File: rtl/txi_bus_dec.sv
module txi_bus_dec
    import tmr_xint_pkg::*;
#(
    parameter int unsigned    ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h88
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_byte,
    input  logic              wr_bit,
    input  logic [REG_W-1:0]  wdata,
    input  logic              bit_val,
    output reg_wr_t           wr
);

    localparam int unsigned IDX_W = $clog2(REG_W);

    logic byte_hit;
    logic bit_hit;
    logic [IDX_W-1:0] bit_idx;

    assign byte_hit = wr_byte && (addr == SFR_ADDR);
    assign bit_hit  = wr_bit && (addr[ADDR_W-1:IDX_W] == SFR_ADDR[ADDR_W-1:IDX_W]);
    assign bit_idx  = addr[IDX_W-1:0];

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        always_comb begin
            if (byte_hit) begin
                wr.en[b]  = 1'b1;
                wr.val[b] = wdata[b];
            end else if (bit_hit && (bit_idx == IDX_W'(b))) begin
                wr.en[b]  = 1'b1;
                wr.val[b] = bit_val;
            end else begin
                wr.en[b]  = 1'b0;
                wr.val[b] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/txi_sync.sv
module txi_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/txi_tmr_flag.sv
module txi_tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic ack,
    input  logic wr_en,
    input  logic wr_val,
    output logic flag
);

    logic flag_d;

    always_comb begin
        if (ovf) begin
            flag_d = 1'b1;
        end else if (ack) begin
            flag_d = 1'b0;
        end else if (wr_en) begin
            flag_d = wr_val;
        end else begin
            flag_d = flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= flag_d;
        end
    end

    AST_TF_SET: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> flag); // R3
    AST_TF_ACK: assert property (@(posedge clk) disable iff (!rst_n) (ack && !ovf) |=> !flag); // R4
    AST_TF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (ovf && (ack || (wr_en && !wr_val))) |=> flag); // R5

endmodule

// File: rtl/txi_xint_chan.sv
module txi_xint_chan
    import tmr_xint_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        FLAG_RST    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic ack,
    input  logic wr_en,
    input  logic wr_val,
    output logic flag
);

    logic       pin_n_sync;
    logic       pin_active;
    logic       fall_evt;
    logic       flag_d;
    pin_state_e state_q;
    pin_state_e state_d;

    txi_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_n),
        .q_sync  (pin_n_sync)
    );

    assign pin_active = ~pin_n_sync;

    // Pin-tracking state machine: FALL and RISE transitions
    always_comb begin
        state_d  = state_q;
        fall_evt = 1'b0;
        unique case (state_q)
            PIN_HIGH: begin
                if (pin_active) begin
                    state_d  = PIN_LOW;
                    fall_evt = 1'b1;
                end
            end
            PIN_LOW: begin
                if (!pin_active) begin
                    state_d = PIN_HIGH;
                end
            end
            default: begin
                state_d = PIN_HIGH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // Flag update: level mode overrides; in edge mode set beats clear
    always_comb begin
        if (!edge_mode) begin
            flag_d = pin_active;
        end else if (fall_evt) begin
            flag_d = 1'b1;
        end else if (ack) begin
            flag_d = 1'b0;
        end else if (wr_en) begin
            flag_d = wr_val;
        end else begin
            flag_d = flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= FLAG_RST;
        end else begin
            flag <= flag_d;
        end
    end

    AST_STATE_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((state_q == PIN_LOW) == $past(pin_active))); // R7
    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n) (edge_mode && fall_evt) |=> flag); // R5
    AST_NO_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) (edge_mode && !flag && !fall_evt && !wr_en) |=> !flag); // R7
    AST_EDGE_ACK: assert property (@(posedge clk) disable iff (!rst_n) (edge_mode && ack && !fall_evt) |=> !flag); // R8
    AST_LVL_TRACK: assert property (@(posedge clk) disable iff (!rst_n) !edge_mode |=> (flag == $past(pin_active))); // R9

endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
    import tmr_xint_pkg::*;
#(
    parameter logic [7:0]  SFR_ADDR    = 8'h88,
    parameter int unsigned N_CH        = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      sfr_addr,
    input  logic            sfr_wr_byte,
    input  logic            sfr_wr_bit,
    input  logic [7:0]      sfr_wdata,
    input  logic            sfr_bit_val,
    input  logic [N_CH-1:0] tmr_ovf,
    input  logic [N_CH-1:0] xint_n,
    input  logic [N_CH-1:0] tmr_ack,
    input  logic [N_CH-1:0] xint_ack,
    output logic [7:0]      sfr_rdata,
    output logic [N_CH-1:0] tmr_run,
    output logic [N_CH-1:0] tmr_irq,
    output logic [N_CH-1:0] xint_irq
);

    localparam logic [REG_W-1:0] CTL_MASK = 8'h55;

    reg_wr_t         wr;
    logic [N_CH-1:0] run_q;
    logic [N_CH-1:0] mode_q;
    logic [N_CH-1:0] tf_q;
    logic [N_CH-1:0] ie_q;

    txi_bus_dec #(
        .ADDR_W   (8),
        .SFR_ADDR (SFR_ADDR)
    ) u_dec (
        .addr    (sfr_addr),
        .wr_byte (sfr_wr_byte),
        .wr_bit  (sfr_wr_bit),
        .wdata   (sfr_wdata),
        .bit_val (sfr_bit_val),
        .wr      (wr)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int unsigned P_TF = pos_tf(c);
        localparam int unsigned P_TR = pos_tr(c);
        localparam int unsigned P_IE = pos_ie(c);
        localparam int unsigned P_IT = pos_it(c);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q[c]  <= 1'b0;
                mode_q[c] <= 1'b0;
            end else begin
                if (wr.en[P_TR]) run_q[c]  <= wr.val[P_TR];
                if (wr.en[P_IT]) mode_q[c] <= wr.val[P_IT];
            end
        end

        txi_tmr_flag u_tf (
            .clk    (clk),
            .rst_n  (rst_n),
            .ovf    (tmr_ovf[c]),
            .ack    (tmr_ack[c]),
            .wr_en  (wr.en[P_TF]),
            .wr_val (wr.val[P_TF]),
            .flag   (tf_q[c])
        );

        txi_xint_chan #(
            .SYNC_STAGES (SYNC_STAGES),
            .FLAG_RST    (1'b1)
        ) u_xi (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (xint_n[c]),
            .edge_mode (mode_q[c]),
            .ack       (xint_ack[c]),
            .wr_en     (wr.en[P_IE]),
            .wr_val    (wr.val[P_IE]),
            .flag      (ie_q[c])
        );

        assign sfr_rdata[P_TF] = tf_q[c];
        assign sfr_rdata[P_TR] = run_q[c];
        assign sfr_rdata[P_IE] = ie_q[c];
        assign sfr_rdata[P_IT] = mode_q[c];
    end

    assign tmr_run  = run_q;
    assign tmr_irq  = tf_q;
    assign xint_irq = ie_q;

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((sfr_wr_byte || sfr_wr_bit) && (sfr_addr[7:3] != SFR_ADDR[7:3])) |=> ((sfr_rdata & CTL_MASK) == $past(sfr_rdata & CTL_MASK))); // R11
    AST_BIT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr_bit && !sfr_wr_byte && (sfr_addr[7:3] == SFR_ADDR[7:3]))
        |=> ((((sfr_rdata ^ $past(sfr_rdata)) & CTL_MASK) & ~(8'h01 << $past(sfr_addr[2:0]))) == 8'h00)); // R10
    AST_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !(sfr_wr_byte || sfr_wr_bit) |=> $stable(tmr_run)); // R6

endmodule

// File: tb/tmr_xint_ctl_test.sv
module tmr_xint_ctl_test;

    logic       clk;
    logic       rst_n;
    logic [7:0] sfr_addr;
    logic       sfr_wr_byte;
    logic       sfr_wr_bit;
    logic [7:0] sfr_wdata;
    logic       sfr_bit_val;
    logic [1:0] tmr_ovf;
    logic [1:0] xint_n;
    logic [1:0] tmr_ack;
    logic [1:0] xint_ack;
    logic [7:0] sfr_rdata;
    logic [1:0] tmr_run;
    logic [1:0] tmr_irq;
    logic [1:0] xint_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    tmr_xint_ctl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sfr_addr    (sfr_addr),
        .sfr_wr_byte (sfr_wr_byte),
        .sfr_wr_bit  (sfr_wr_bit),
        .sfr_wdata   (sfr_wdata),
        .sfr_bit_val (sfr_bit_val),
        .tmr_ovf     (tmr_ovf),
        .xint_n      (xint_n),
        .tmr_ack     (tmr_ack),
        .xint_ack    (xint_ack),
        .sfr_rdata   (sfr_rdata),
        .tmr_run     (tmr_run),
        .tmr_irq     (tmr_irq),
        .xint_irq    (xint_irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr_byte = 1'b1;
        cyc(1);
        sfr_wr_byte = 1'b0;
    endtask

    task automatic wr_bit(input logic [7:0] a, input logic v);
        sfr_addr = a; sfr_bit_val = v; sfr_wr_bit = 1'b1;
        cyc(1);
        sfr_wr_bit = 1'b0;
    endtask

    task automatic t_reset;
        check("R2 reset value", sfr_rdata, 8'h0A);
        check("R12 reset ext irq", {6'b0, xint_irq}, 8'h03);
        rst_n = 1'b1;
        cyc(2);
        check("R9 level flags follow idle pins", sfr_rdata, 8'h00);
    endtask

    task automatic t_byte_and_foreign;
        wr_byte(8'h88, 8'h55);
        check("R1 byte write", sfr_rdata, 8'h55);
        check("R6 run outputs", {6'b0, tmr_run}, 8'h03);
        wr_byte(8'h89, 8'hFF);
        check("R11 foreign byte address", sfr_rdata, 8'h55);
        wr_bit(8'h94, 1'b0);
        check("R11 foreign bit address", sfr_rdata, 8'h55);
        wr_byte(8'h88, 8'h00);
        check("R1 byte clear", sfr_rdata, 8'h00);
    endtask

    task automatic t_bit_write;
        wr_bit(8'h8E, 1'b1);
        check("R10 set bit 6", sfr_rdata, 8'h40);
        check("R6 run1 via bit", {6'b0, tmr_run}, 8'h02);
        wr_bit(8'h8C, 1'b1);
        check("R10 set bit 4", sfr_rdata, 8'h50);
        wr_bit(8'h8E, 1'b0);
        check("R10 clear bit 6", sfr_rdata, 8'h10);
        check("R6 run0 only", {6'b0, tmr_run}, 8'h01);
        wr_bit(8'h8C, 1'b0);
        check("R10 clear bit 4", sfr_rdata, 8'h00);
    endtask

    task automatic t_timer_flags;
        tmr_ovf[0] = 1'b1; cyc(1); tmr_ovf[0] = 1'b0;
        check("R3 ovf0 sets bit 5", sfr_rdata, 8'h20);
        check("R12 tmr_irq0", {6'b0, tmr_irq}, 8'h01);
        tmr_ack[0] = 1'b1; cyc(1); tmr_ack[0] = 1'b0;
        check("R4 ack0 clears", sfr_rdata, 8'h00);
        tmr_ovf[1] = 1'b1; cyc(1); tmr_ovf[1] = 1'b0;
        check("R3 ovf1 sets bit 7", sfr_rdata, 8'h80);
        wr_bit(8'h8F, 1'b0);
        check("R4 software clear tf1", sfr_rdata, 8'h00);
        tmr_ovf[0] = 1'b1; tmr_ack[0] = 1'b1; cyc(1);
        tmr_ovf[0] = 1'b0; tmr_ack[0] = 1'b0;
        check("R5 ovf beats ack", sfr_rdata, 8'h20);
        tmr_ack[0] = 1'b1; cyc(1); tmr_ack[0] = 1'b0;
        tmr_ovf[1] = 1'b1;
        wr_byte(8'h88, 8'h00);
        tmr_ovf[1] = 1'b0;
        check("R5 ovf beats write", sfr_rdata, 8'h80);
        wr_byte(8'h88, 8'h00);
        check("R4 byte clear", sfr_rdata, 8'h00);
    endtask

    task automatic t_edge0;
        wr_bit(8'h88, 1'b1);
        check("R1 edge mode bit 0", sfr_rdata, 8'h01);
        xint_n[0] = 1'b0;
        cyc(2);
        check("R7 not yet latched", sfr_rdata, 8'h01);
        cyc(1);
        check("R7 edge latched third edge", sfr_rdata, 8'h03);
        check("R12 xint_irq0", {6'b0, xint_irq}, 8'h01);
        xint_ack[0] = 1'b1; cyc(1); xint_ack[0] = 1'b0;
        check("R8 ack clears edge flag", sfr_rdata, 8'h01);
        cyc(5);
        check("R7 held-low pin no reset", sfr_rdata, 8'h01);
        xint_n[0] = 1'b1;
        cyc(5);
        check("R7 rising edge ignored", sfr_rdata, 8'h01);
        xint_n[0] = 1'b0;
        cyc(2);
        xint_ack[0] = 1'b1; cyc(1); xint_ack[0] = 1'b0;
        check("R5 edge beats ack", sfr_rdata, 8'h03);
        wr_bit(8'h89, 1'b0);
        check("R8 software clear", sfr_rdata, 8'h01);
        xint_n[0] = 1'b1;
        cyc(4);
        wr_byte(8'h88, 8'h00);
        check("R1 back to level", sfr_rdata, 8'h00);
    endtask

    task automatic t_level1;
        xint_n[1] = 1'b0;
        cyc(2);
        check("R9 level not yet", sfr_rdata, 8'h00);
        cyc(1);
        check("R9 level follows pin", sfr_rdata, 8'h08);
        xint_ack[1] = 1'b1; cyc(1); xint_ack[1] = 1'b0;
        check("R9 ack ignored", sfr_rdata, 8'h08);
        wr_bit(8'h8B, 1'b0);
        check("R9 write 0 ignored", sfr_rdata, 8'h08);
        xint_n[1] = 1'b1;
        cyc(3);
        check("R9 pin release", sfr_rdata, 8'h00);
        wr_bit(8'h8B, 1'b1);
        check("R9 write 1 ignored", sfr_rdata, 8'h00);
        check("R12 xint_irq idle", {6'b0, xint_irq}, 8'h00);
    endtask

    task automatic t_edge1;
        wr_bit(8'h8A, 1'b1);
        xint_n[1] = 1'b0;
        cyc(3);
        check("R7 edge ch1", sfr_rdata, 8'h0C);
        xint_ack[1] = 1'b1; cyc(1); xint_ack[1] = 1'b0;
        check("R8 ack ch1", sfr_rdata, 8'h04);
        xint_n[1] = 1'b1;
        cyc(3);
    endtask

    initial begin
        rst_n = 1'b0;
        sfr_addr = 8'h00; sfr_wr_byte = 1'b0; sfr_wr_bit = 1'b0;
        sfr_wdata = 8'h00; sfr_bit_val = 1'b0;
        tmr_ovf = 2'b00; xint_n = 2'b11; tmr_ack = 2'b00; xint_ack = 2'b00;
        cyc(3);
        t_reset();
        t_byte_and_foreign();
        t_bit_write();
        t_timer_flags();
        t_edge0();
        t_level1();
        t_edge1();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule